// File: doc/BRIEF.md
# FM Operator Phase Generator with Percussion Noise

This block advances the phase of the operators in a time-multiplexed FM synthesizer. The sequencer of the voice engine visits one operator slot per strobe. For that slot it presents the frequency number, the octave block, the frequency multiplier (already converted to its numeric factor), a phase-clear flag and the percussion-mode enable. The block keeps a wrapping phase accumulator per slot. One clock after the strobe it returns the 10-bit phase that the waveform stage of that operator uses.

A 23-bit linear feedback shift register supplies noise that all slots share. It moves one step per strobe. When percussion mode is on, three fixed slots (hi-hat, snare and cymbal) do not use their own accumulator phase. Their phases are built from noise and from phase bits sampled earlier from the hi-hat and cymbal slots, which gives the metallic and noisy drum timbres.

Top module: `opfm_phase_gen`

## Requirements
- R1: After a strobe, `valid_o` is high for exactly the next clock cycle and `phase_o` holds the result of that strobe. `valid_o` is low in every cycle that does not follow a strobe.
- R2: For an ordinary slot, `phase_o` is bits 18..9 of that slot's 19-bit accumulator, read before this strobe's update. Each slot has its own accumulator, and all accumulators are zero after reset.
- R3: On each strobe the slot's accumulator adds (((fnum << block) >> 1) * mult) >> 1, modulo 2^19.
- R4: When the clear flag is set, the accumulator is zeroed before the increment is added, so it ends holding just the increment. The phase returned for that strobe is still the value from before the clear.
- R5: The noise register is 23 bits wide and resets to 1. On every strobe it shifts right by one, and bit 14 XOR bit 0 enters bit 22. The noise bit used by a strobe is bit 0 before that strobe's shift.
- R6: Every strobe to slot 13 samples its phase bits 2, 3, 7 and 8 (h2, h3, h7, h8). A strobe to slot 17 samples its phase bits 3 and 5 (c3, c5) only when percussion mode is on. All sampled bits reset to 0. A strobe uses the bits sampled by that same strobe. Define m = (h2^h7) | (h3^c5) | (c3^c5).
- R7: In percussion mode slot 13 returns m in bit 9. Its low nine bits are 0x0D0 when m XOR noise is 1, and 0x034 otherwise.
- R8: In percussion mode slot 16 returns h8 in bit 9 and h8 XOR noise in bit 8, with all other bits zero.
- R9: In percussion mode slot 17 returns m in bit 9 and 0x080 in its low nine bits.
- R10: With percussion mode off, slots 13, 16 and 17 return their ordinary accumulator phase. Their accumulators advance normally in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | Evaluate the slot presented this cycle |
| slot_i | input | 6 | Slot number, 0 to 35 |
| fnum_i | input | 10 | Frequency number |
| block_i | input | 3 | Octave block (left shift of fnum) |
| mult_i | input | 5 | Multiplier factor, 0 to 31 |
| ph_clr_i | input | 1 | Clear the slot accumulator before adding |
| rhythm_i | input | 1 | Percussion mode enable |
| phase_o | output | 10 | Operator phase for the last strobe |
| valid_o | output | 1 | `phase_o` is fresh this cycle |

## Verification
Every result is due exactly one clock after its strobe. This covers the returned phase, the noise bit folded into it, and the effect of the bit sampling. The accumulator, noise register and sampled bits take their new values at the strobe's clock edge, so the next strobe sees them. The bench drives a strobe on a falling edge and samples `phase_o` and `valid_o` on the following falling edge. It then checks one cycle later that `valid_o` has dropped. Because strobes are spaced two cycles apart, no check overlaps the next update. Expected values come from a bench-side model of the requirements, which is advanced once per strobe.

// File: rtl/opfm_pkg.sv
package opfm_pkg;

   // Which percussion substitution applies to the current strobe
   typedef enum logic [1:0] {
      ROLE_PLAIN = 2'd0,
      ROLE_HAT   = 2'd1,
      ROLE_SNARE = 2'd2,
      ROLE_CYM   = 2'd3
   } perc_role_e;

   localparam int unsigned HAT_LOW_ON  = 9'h0D0;
   localparam int unsigned HAT_LOW_OFF = 9'h034;
   localparam int unsigned CYM_LOW     = 9'h080;

endpackage

// File: rtl/opfm_noise_lfsr.sv
module opfm_noise_lfsr #(
   parameter int unsigned WIDTH = 23,
   parameter int unsigned TAP   = 14,
   parameter logic [WIDTH-1:0] SEED = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   output logic noise_bit
);

   if (TAP == 0 || TAP >= WIDTH) begin : g_bad_tap
      $error("opfm_noise_lfsr: TAP must lie in 1..WIDTH-1");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("opfm_noise_lfsr: SEED must be nonzero");
   end

   logic [WIDTH-1:0] sr_q;
   logic             feed;

   assign feed      = sr_q[TAP] ^ sr_q[0];
   assign noise_bit = sr_q[0];

   always_ff @(posedge clk) begin
      if (!rst_n)      sr_q <= SEED;
      else if (step)   sr_q <= {feed, sr_q[WIDTH-1:1]};
   end

   // R5: a nonzero seed can never reach the all-zero lock-up state
   a_r5_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
      sr_q != '0);

   // R5: the register only moves when a strobe steps it
   a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(sr_q));

endmodule

// File: rtl/opfm_phase_store.sv
module opfm_phase_store #(
   parameter int unsigned NUM_SLOTS = 36,
   parameter int unsigned ACC_W     = 19,
   parameter int unsigned PH_W      = 10,
   parameter int unsigned FNUM_W    = 10,
   parameter int unsigned BLK_W     = 3,
   parameter int unsigned MUL_W     = 5,
   localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS),
   localparam int unsigned SH_W     = FNUM_W + (1 << BLK_W) - 1,
   localparam int unsigned PROD_W   = SH_W - 1 + MUL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] slot,
   input  logic [FNUM_W-1:0] fnum,
   input  logic [BLK_W-1:0]  block,
   input  logic [MUL_W-1:0]  mult,
   input  logic              clr,
   output logic [PH_W-1:0]   phase_old
);

   localparam int unsigned FRAC_W = ACC_W - PH_W;

   if (PH_W >= ACC_W) begin : g_bad_width
      $error("opfm_phase_store: accumulator must be wider than phase");
   end
   if (PROD_W - 1 < ACC_W) begin : g_bad_prod
      $error("opfm_phase_store: increment narrower than accumulator");
   end

   logic [ACC_W-1:0]  acc_q [NUM_SLOTS];
   logic [NUM_SLOTS-1:0] hit;
   logic [SH_W-1:0]   shifted;
   logic [PROD_W-1:0] prod;
   logic [ACC_W-1:0]  inc;
   logic [ACC_W-1:0]  cur;
   logic [ACC_W-1:0]  nxt;

   // one write-enable per slot
   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_hit
      assign hit[g] = wr_en && (slot == SLOT_W'(g));
   end

   always_comb begin
      shifted = SH_W'(fnum) << block;
      prod    = PROD_W'(shifted >> 1) * PROD_W'(mult);
      inc     = prod[ACC_W:1];
      cur     = (int'(slot) < NUM_SLOTS) ? acc_q[slot] : '0;
      nxt     = (clr ? '0 : cur) + inc;
   end

   assign phase_old = cur[ACC_W-1:FRAC_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_SLOTS; i++) acc_q[i] <= '0;
      end else begin
         for (int i = 0; i < NUM_SLOTS; i++) begin
            if (hit[i]) acc_q[i] <= nxt;
         end
      end
   end

   // R2: at most one accumulator written per strobe
   a_r2_single_write: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));

   // R4: a cleared zero-increment update leaves the slot at zero
   a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && clr && (fnum == '0) && (int'(slot) < NUM_SLOTS))
      |=> (acc_q[$past(slot)] == '0));

endmodule

// File: rtl/opfm_perc_phase.sv
module opfm_perc_phase
   import opfm_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 36,
   parameter int unsigned PH_W      = 10,
   parameter int unsigned HAT_SLOT  = 13,
   parameter int unsigned SNR_SLOT  = 16,
   parameter int unsigned CYM_SLOT  = 17,
   localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [SLOT_W-1:0] slot,
   input  logic              rhythm,
   input  logic              noise_bit,
   input  logic [PH_W-1:0]   acc_phase,
   output logic [PH_W-1:0]   phase_out,
   output perc_role_e        role
);

   if (PH_W < 10) begin : g_bad_ph
      $error("opfm_perc_phase: phase must be at least 10 bits");
   end
   if (HAT_SLOT >= NUM_SLOTS || SNR_SLOT >= NUM_SLOTS || CYM_SLOT >= NUM_SLOTS) begin : g_bad_slot
      $error("opfm_perc_phase: percussion slot out of range");
   end

   logic [3:0] hat_q, hat_n;   // {h8, h7, h3, h2}
   logic [1:0] cym_q, cym_n;   // {c5, c3}
   logic       is_hat, is_snr, is_cym;
   logic       mix;

   assign is_hat = (slot == SLOT_W'(HAT_SLOT));
   assign is_snr = (slot == SLOT_W'(SNR_SLOT));
   assign is_cym = (slot == SLOT_W'(CYM_SLOT));

   // read-through: a strobe sees the bits it samples itself
   always_comb begin
      hat_n = hat_q;
      cym_n = cym_q;
      if (en && is_hat)           hat_n = {acc_phase[8], acc_phase[7], acc_phase[3], acc_phase[2]};
      if (en && is_cym && rhythm) cym_n = {acc_phase[5], acc_phase[3]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hat_q <= '0;
         cym_q <= '0;
      end else begin
         hat_q <= hat_n;
         cym_q <= cym_n;
      end
   end

   assign mix = (hat_n[0] ^ hat_n[2]) | (hat_n[1] ^ cym_n[1]) | (cym_n[0] ^ cym_n[1]);

   always_comb begin
      role = ROLE_PLAIN;
      if (rhythm) begin
         if (is_hat)      role = ROLE_HAT;
         else if (is_snr) role = ROLE_SNARE;
         else if (is_cym) role = ROLE_CYM;
      end
   end

   always_comb begin
      phase_out = acc_phase;
      case (role)
         ROLE_HAT:   phase_out = PH_W'({mix, 9'h000})
                               | ((mix ^ noise_bit) ? PH_W'(HAT_LOW_ON) : PH_W'(HAT_LOW_OFF));
         ROLE_SNARE: phase_out = PH_W'({hat_n[3], hat_n[3] ^ noise_bit, 8'h00});
         ROLE_CYM:   phase_out = PH_W'({mix, 9'h000}) | PH_W'(CYM_LOW);
         default:    phase_out = acc_phase;
      endcase
   end

   // R6: cymbal bits are not resampled while percussion mode is off
   a_r6_cym_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !rhythm) |=> $stable(cym_q));

   // R6: hat bits change only on a hat-slot strobe
   a_r6_hat_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(en && is_hat) |=> $stable(hat_q));

endmodule

// File: rtl/opfm_phase_gen.sv
module opfm_phase_gen
   import opfm_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 36,
   parameter int unsigned ACC_W     = 19,
   parameter int unsigned PH_W      = 10,
   parameter int unsigned FNUM_W    = 10,
   parameter int unsigned BLK_W     = 3,
   parameter int unsigned MUL_W     = 5,
   parameter int unsigned NOISE_W   = 23,
   parameter int unsigned NOISE_TAP = 14,
   localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe_i,
   input  logic [SLOT_W-1:0] slot_i,
   input  logic [FNUM_W-1:0] fnum_i,
   input  logic [BLK_W-1:0]  block_i,
   input  logic [MUL_W-1:0]  mult_i,
   input  logic              ph_clr_i,
   input  logic              rhythm_i,
   output logic [PH_W-1:0]   phase_o,
   output logic              valid_o
);

   logic [PH_W-1:0] acc_phase;
   logic [PH_W-1:0] mixed_phase;
   logic            noise_bit;
   perc_role_e      role, role_q;

   opfm_phase_store #(
      .NUM_SLOTS(NUM_SLOTS), .ACC_W(ACC_W), .PH_W(PH_W),
      .FNUM_W(FNUM_W), .BLK_W(BLK_W), .MUL_W(MUL_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(strobe_i), .slot(slot_i),
      .fnum(fnum_i), .block(block_i), .mult(mult_i), .clr(ph_clr_i),
      .phase_old(acc_phase)
   );

   opfm_noise_lfsr #(
      .WIDTH(NOISE_W), .TAP(NOISE_TAP), .SEED(NOISE_W'(1))
   ) u_noise (
      .clk(clk), .rst_n(rst_n), .step(strobe_i), .noise_bit(noise_bit)
   );

   opfm_perc_phase #(
      .NUM_SLOTS(NUM_SLOTS), .PH_W(PH_W)
   ) u_perc (
      .clk(clk), .rst_n(rst_n), .en(strobe_i), .slot(slot_i),
      .rhythm(rhythm_i), .noise_bit(noise_bit), .acc_phase(acc_phase),
      .phase_out(mixed_phase), .role(role)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_o <= '0;
         valid_o <= 1'b0;
         role_q  <= ROLE_PLAIN;
      end else begin
         valid_o <= strobe_i;
         if (strobe_i) begin
            phase_o <= mixed_phase;
            role_q  <= role;
         end
      end
   end

   // R1: result valid exactly one cycle after each strobe
   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_i |=> valid_o);
   a_r1_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_i |=> !valid_o);

   // R7: hat phase low bits are one of the two fixed patterns
   a_r7_hat_pattern: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && role_q == ROLE_HAT) |->
      (phase_o[8:0] == 9'h0D0 || phase_o[8:0] == 9'h034));

   // R8: snare phase has no bits below bit 8
   a_r8_snare_low: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && role_q == ROLE_SNARE) |-> (phase_o[7:0] == 8'h00));

   // R9: cymbal phase low bits fixed
   a_r9_cym_low: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && role_q == ROLE_CYM) |-> (phase_o[8:0] == 9'h080));

endmodule

// File: tb/opfm_phase_gen_test.sv
module opfm_phase_gen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       strobe_i = 1'b0;
   logic [5:0] slot_i = '0;
   logic [9:0] fnum_i = '0;
   logic [2:0] block_i = '0;
   logic [4:0] mult_i = '0;
   logic       ph_clr_i = 1'b0;
   logic       rhythm_i = 1'b0;
   logic [9:0] phase_o;
   logic       valid_o;

   always #10 clk = ~clk;   // 50 MHz

   opfm_phase_gen uut (
      .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .slot_i(slot_i),
      .fnum_i(fnum_i), .block_i(block_i), .mult_i(mult_i),
      .ph_clr_i(ph_clr_i), .rhythm_i(rhythm_i),
      .phase_o(phase_o), .valid_o(valid_o)
   );

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // requirement-level model
   logic [18:0] m_acc [36];
   logic [22:0] m_noise;
   logic [3:0]  m_hat;   // {h8,h7,h3,h2}
   logic [1:0]  m_cym;   // {c5,c3}

   // stimulus table: {slot, fnum, block, mult, clear, rhythm}
   localparam int NV = 16;
   localparam logic [25:0] VEC [NV] = '{
      {6'd16, 10'd300, 3'd4, 5'd2,  1'b0, 1'b1},  // snare first: sampled bits still 0
      {6'd0,  10'd512, 3'd4, 5'd2,  1'b0, 1'b0},
      {6'd0,  10'd512, 3'd4, 5'd2,  1'b0, 1'b0},
      {6'd1,  10'd1023,3'd7, 5'd30, 1'b0, 1'b0},
      {6'd1,  10'd1023,3'd7, 5'd30, 1'b0, 1'b0},
      {6'd0,  10'd512, 3'd4, 5'd2,  1'b1, 1'b0},
      {6'd0,  10'd512, 3'd4, 5'd2,  1'b0, 1'b0},
      {6'd13, 10'd777, 3'd5, 5'd3,  1'b0, 1'b0},
      {6'd13, 10'd777, 3'd5, 5'd3,  1'b0, 1'b0},
      {6'd17, 10'd401, 3'd6, 5'd5,  1'b0, 1'b0},
      {6'd17, 10'd401, 3'd6, 5'd5,  1'b0, 1'b0},
      {6'd16, 10'd300, 3'd4, 5'd2,  1'b0, 1'b0},
      {6'd35, 10'd1,   3'd0, 5'd1,  1'b0, 1'b0},
      {6'd13, 10'd777, 3'd5, 5'd3,  1'b0, 1'b1},
      {6'd17, 10'd401, 3'd6, 5'd5,  1'b0, 1'b1},
      {6'd16, 10'd300, 3'd4, 5'd2,  1'b0, 1'b1}
   };

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [18:0] model_inc(input logic [9:0] f, input logic [2:0] b,
                                             input logic [4:0] m);
      logic [16:0] sh;
      logic [20:0] p;
      sh = 17'(f) << b;
      p  = 21'(sh >> 1) * 21'(m);
      return p[19:1];
   endfunction

   // advances the model and returns the expected phase
   function automatic logic [9:0] model_step(input logic [5:0] s, input logic [9:0] f,
         input logic [2:0] b, input logic [4:0] m, input logic c, input logic r);
      logic [9:0] ph, res;
      logic n, x;
      ph = m_acc[s][18:9];
      n  = m_noise[0];
      if (s == 6'd13)      m_hat = {ph[8], ph[7], ph[3], ph[2]};
      if (s == 6'd17 && r) m_cym = {ph[5], ph[3]};
      x = (m_hat[0] ^ m_hat[2]) | (m_hat[1] ^ m_cym[1]) | (m_cym[0] ^ m_cym[1]);
      res = ph;
      if (r && s == 6'd13) res = {x, ((x ^ n) ? 9'h0D0 : 9'h034)};
      if (r && s == 6'd16) res = {m_hat[3], m_hat[3] ^ n, 8'h00};
      if (r && s == 6'd17) res = {x, 9'h080};
      m_acc[s] = (c ? 19'd0 : m_acc[s]) + model_inc(f, b, m);
      m_noise  = {m_noise[14] ^ m_noise[0], m_noise[22:1]};
      return res;
   endfunction

   task automatic do_op(input logic [5:0] s, input logic [9:0] f, input logic [2:0] b,
                        input logic [4:0] m, input logic c, input logic r, input string req);
      logic [9:0] exp;
      @(negedge clk);
      check("R1 idle valid low", int'(valid_o), 0);
      slot_i = s; fnum_i = f; block_i = b; mult_i = m; ph_clr_i = c; rhythm_i = r;
      strobe_i = 1'b1;
      exp = model_step(s, f, b, m, c, r);
      @(negedge clk);
      strobe_i = 1'b0;
      check("R1 valid after strobe", int'(valid_o), 1);
      check(req, int'(phase_o), int'(exp));
   endtask

   initial begin
      for (int i = 0; i < 36; i++) m_acc[i] = '0;
      m_noise = 23'd1;
      m_hat = '0;
      m_cym = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset valid", int'(valid_o), 0);
      check("R2 reset phase", int'(phase_o), 0);

      // table walk; first entry: R6 reset bits with R8 snare, noise seed 1 gives 0x100
      for (int v = 0; v < NV; v++) begin
         do_op(VEC[v][25:20], VEC[v][19:10], VEC[v][9:7], VEC[v][6:2], VEC[v][1], VEC[v][0],
               "R2 R3 R4 R6 R7 R8 R9 R10 table");
      end

      // R4: clear returns the old phase, then restarts from the increment
      repeat (5) do_op(6'd5, 10'd900, 3'd7, 5'd12, 1'b0, 1'b0, "R3 wrap run");
      do_op(6'd5, 10'd900, 3'd7, 5'd12, 1'b1, 1'b0, "R4 clear keeps old phase");
      do_op(6'd5, 10'd0,   3'd0, 5'd0,  1'b0, 1'b0, "R4 restart from increment");

      // R5 R7 R8 R9: long percussion run exercising the noise sequence
      for (int k = 0; k < 300; k++) begin
         do_op(6'd13, 10'(k * 37 + 5), 3'(k % 8), 5'(k % 31 + 1), 1'b0, 1'b1, "R7 hat");
         do_op(6'd16, 10'(k * 11 + 3), 3'd3, 5'd4, 1'b0, 1'b1, "R8 snare noise R5");
         do_op(6'd17, 10'(k * 53 + 9), 3'((k + 3) % 8), 5'd7, 1'b0, 1'b1, "R9 cymbal");
         do_op(6'(k % 36), 10'(k * 7), 3'd2, 5'd1, 1'b0, (k % 2) == 1, "R10 other slot");
      end

      // R6 R10: cymbal strobes with percussion off must not resample c3/c5
      do_op(6'd17, 10'd611, 3'd7, 5'd9, 1'b0, 1'b0, "R10 cymbal slot plain");
      do_op(6'd17, 10'd611, 3'd7, 5'd9, 1'b0, 1'b0, "R10 cymbal slot plain");
      do_op(6'd13, 10'd222, 3'd6, 5'd6, 1'b0, 1'b1, "R6 cymbal bits held");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule